// File: doc/BRIEF.md
# Strobe-Handshake Host Bus Slave

This block sits between an asynchronous-style host bus and an internal register or memory space. The host has chip select, address strobe, upper and lower data strobes, a read/write line, a memory/register select and a word address. It finishes each access when the slave pulls the acknowledge line low. The slave samples every host signal on the rising edge of its own bus clock. It recognises a cycle when select, address strobe and at least one data strobe are all low. It then issues a single byte-enabled request on a simple internal port and holds off the acknowledge for a minimum number of clocks. That minimum depends on the selected memory-clock ratio.

Reads are requested as soon as a cycle is recognised. The internal port returns data after a fixed latency, and the slave holds that data in a read buffer that it drives onto the host bus. Writes are latched from the host bus into a write buffer on a fixed edge of the cycle. They are issued internally only once the acknowledge goes low, so a cycle the host abandons early never reaches the internal space. The acknowledge line and the data bus are three-state; each is modelled as a value output plus an enable output.

Top module: `hbs_bus_slave`

## Requirements
- R1: A cycle starts only on a rising edge where `cs_n_i`, `as_n_i` and at least one of `uds_n_i`/`lds_n_i` are all low. With both data strobes high, no request is issued and `dtack_n_o` stays high.
- R2: While the block is idle, `dtack_oe_o` is high and `dtack_n_o` is high in the same cycle in which `cs_n_i` and `as_n_i` are both low.
- R3: `dtack_n_o` first goes low after the Nth rising edge of the cycle, where the recognising edge is edge 1. N comes from `cfg_div_i` sampled at that edge: 00 gives 8, 01 gives 11, 10 gives 13 and 11 gives 18. With the default read latency this holds for reads as well.
- R4: On a write, the word stored is the value on `data_i` at the third rising edge of the cycle. Values present at other edges are not stored.
- R5: Bit 1 of a byte enable is the upper lane `[15:8]` (from `uds_n_i`) and bit 0 is the lower lane `[7:0]` (from `lds_n_i`). A write request carries the enables of the cycle, which are never zero, so only the enabled lanes change.
- R6: On a read, `data_oe_o` is high once the cycle is recognised while a data strobe is low. `data_o` carries the full addressed word whenever `dtack_n_o` is low, whichever lanes were strobed.
- R7: `data_oe_o` is low in any cycle where both data strobes are high.
- R8: Once `as_n_i` is high, `dtack_n_o` is high. `dtack_oe_o` falls on the first rising edge at which `as_n_i` is sampled high.
- R9: If `as_n_i` rises before the acknowledge, no write request is issued. The block returns to idle on that edge, and the target word keeps its old value.
- R10: One host cycle causes exactly one internal request, even when the host keeps its strobes low for many clocks after the acknowledge. A new cycle is accepted only after the acknowledge line has been released.
- R11: A read request (`req_o` high, `req_we_o` low, with the latched address, select and byte enables) is a one-cycle pulse right after the recognising edge. A write request is a one-cycle pulse right after the edge that drives `dtack_n_o` low. Read data on `rd_data_i` is sampled on the RD_LAT-th rising edge after the request pulse ends.
- R12: During and right after reset, `dtack_oe_o`, `data_oe_o` and `req_o` are low and `dtack_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div_i | input | 2 | Memory-clock ratio code |
| cs_n_i | input | 1 | Chip select, active low |
| as_n_i | input | 1 | Address strobe, active low |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| mr_i | input | 1 | Memory/register space select |
| addr_i | input | AW | Word address |
| data_i | input | DW | Host write data |
| data_o | output | DW | Host read data |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| dtack_n_o | output | 1 | Acknowledge value, active low |
| dtack_oe_o | output | 1 | Drive enable for the acknowledge |
| req_o | output | 1 | Internal request pulse |
| req_we_o | output | 1 | Internal request is a write |
| req_mr_o | output | 1 | Space select of the request |
| req_addr_o | output | AW | Word address of the request |
| req_be_o | output | 2 | Byte enables, bit 1 upper lane |
| req_wdata_o | output | DW | Write data of the request |
| rd_data_i | input | DW | Internal read data, fixed latency |

## Verification
Every clock, the assertions check these rules: an acknowledge is only low while it is driven, the data bus is never driven with both strobes high, and the acknowledge is released one edge after the address strobe is seen high. They also check that requests are single-cycle pulses, that write requests never carry empty byte enables, and that no acknowledge comes sooner than the shortest ratio allows. The exact acknowledge edge for each ratio, the capture of write data on the third edge and the effect of lane-limited writes on stored words need the bench's scenarios. So do an aborted write leaving memory untouched and long-held strobes giving a single request. The bench checks these through a scoreboard of read-back values.

// File: rtl/hbs_pkg.sv
`timescale 1ns/1ps
package hbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_ACK    = 2'd2
   } hbs_state_e;

   // Minimum acknowledge edge for a ratio code
   function automatic int unsigned min_edges(input logic [1:0] code,
                                             input int unsigned m1,
                                             input int unsigned m2,
                                             input int unsigned m3,
                                             input int unsigned m4);
      case (code)
         2'd0:    min_edges = m1;
         2'd1:    min_edges = m2;
         2'd2:    min_edges = m3;
         default: min_edges = m4;
      endcase
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      max4 = m;
   endfunction

endpackage

// File: rtl/hbs_cycle_ctrl.sv
`timescale 1ns/1ps
module hbs_cycle_ctrl
   import hbs_pkg::*;
#(
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned MIN_D1 = 8,
   parameter int unsigned MIN_D2 = 11,
   parameter int unsigned MIN_D3 = 13,
   parameter int unsigned MIN_D4 = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       as_n_i,
   input  logic       uds_n_i,
   input  logic       lds_n_i,
   input  logic       rw_i,
   input  logic [1:0] cfg_div_i,
   input  logic       rd_ready_i,
   output hbs_state_e state_o,
   output logic       accept_o,
   output logic       cont_o,
   output logic       cap_wr_o,
   output logic       ack_go_o,
   output logic       is_read_o
);

   localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CAP_EDGE = CNT_W'(2);

   hbs_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_inc, min_q;
   logic             rd_q;
   logic             any_strobe, abort, ready;

   assign any_strobe = ~uds_n_i | ~lds_n_i;
   assign accept_o   = (state_q == ST_IDLE) & ~cs_n_i & ~as_n_i & any_strobe;
   assign abort      = (state_q == ST_ACTIVE) & (as_n_i | cs_n_i);
   assign cont_o     = (state_q == ST_ACTIVE) & ~abort;
   assign cnt_inc    = cnt_q + CNT_W'(1);
   assign ready      = rd_q ? rd_ready_i : 1'b1;
   assign ack_go_o   = cont_o & (cnt_inc >= min_q) & ready;
   assign cap_wr_o   = cont_o & ~rd_q & (cnt_q == CAP_EDGE);
   assign is_read_o  = rd_q;
   assign state_o    = state_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (accept_o) state_d = ST_ACTIVE;
         ST_ACTIVE: begin
            if (abort)         state_d = ST_IDLE;
            else if (ack_go_o) state_d = ST_ACK;
         end
         ST_ACK:    if (as_n_i) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         min_q   <= '0;
         rd_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_o) begin
            cnt_q <= CNT_W'(1);
            min_q <= CNT_W'(min_edges(cfg_div_i, MIN_D1, MIN_D2, MIN_D3, MIN_D4));
            rd_q  <= rw_i;
         end else if (cont_o && cnt_q != CNT_SAT) begin
            cnt_q <= cnt_inc;
         end
      end
   end

endmodule

// File: rtl/hbs_wr_buffer.sv
`timescale 1ns/1ps
module hbs_wr_buffer #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_i,
   input  logic          uds_n_i,
   input  logic          lds_n_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] wbuf_o,
   output logic [1:0]    be_o
);

   localparam int unsigned LANE_W = DW / 2;

   logic [1:0] lane_en;
   assign lane_en = {~uds_n_i, ~lds_n_i};

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (cap_i && lane_en[g]) begin
            lane_q <= data_i[g*LANE_W +: LANE_W];
         end
      end
      assign wbuf_o[g*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     be_o <= 2'b00;
      else if (cap_i) be_o <= lane_en;
   end

endmodule

// File: rtl/hbs_rd_path.sv
`timescale 1ns/1ps
module hbs_rd_path #(
   parameter int unsigned DW     = 16,
   parameter int unsigned RD_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  logic          cont_i,
   input  logic          in_cycle_i,
   input  logic          is_read_i,
   input  logic          uds_n_i,
   input  logic          lds_n_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          ready_o,
   output logic [DW-1:0] data_o,
   output logic          data_oe_o
);

   logic          ready_q;
   logic [DW-1:0] rbuf_q;
   logic          take;

   if (RD_LAT == 1) begin : g_lat_one
      // Sample on the first edge after the request pulse
      logic armed_q;
      assign take = cont_i & armed_q & ~ready_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        armed_q <= 1'b0;
         else if (accept_i) armed_q <= 1'b0;
         else if (cont_i)   armed_q <= 1'b1;
      end
   end else begin : g_lat_cnt
      localparam int unsigned LW = $clog2(RD_LAT + 1);
      localparam logic [LW-1:0] LAT_END = LW'(RD_LAT);
      logic [LW-1:0] lat_q;
      assign take = cont_i & ~ready_q & (lat_q == LAT_END);
      always_ff @(posedge clk) begin
         if (!rst_n)                         lat_q <= '0;
         else if (accept_i)                  lat_q <= '0;
         else if (cont_i && lat_q != LAT_END) lat_q <= lat_q + LW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rbuf_q  <= '0;
      end else if (accept_i) begin
         ready_q <= 1'b0;
      end else if (take) begin
         ready_q <= 1'b1;
         rbuf_q  <= rd_data_i;
      end
   end

   assign ready_o   = ready_q;
   assign data_o    = rbuf_q;
   assign data_oe_o = in_cycle_i & is_read_i & (~uds_n_i | ~lds_n_i);

endmodule

// File: rtl/hbs_bus_slave.sv
`timescale 1ns/1ps
module hbs_bus_slave
   import hbs_pkg::*;
#(
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 16,
   parameter int unsigned RD_LAT = 2,
   parameter int unsigned MIN_D1 = 8,
   parameter int unsigned MIN_D2 = 11,
   parameter int unsigned MIN_D3 = 13,
   parameter int unsigned MIN_D4 = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_div_i,
   input  logic          cs_n_i,
   input  logic          as_n_i,
   input  logic          uds_n_i,
   input  logic          lds_n_i,
   input  logic          rw_i,
   input  logic          mr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] data_o,
   output logic          data_oe_o,
   output logic          dtack_n_o,
   output logic          dtack_oe_o,
   output logic          req_o,
   output logic          req_we_o,
   output logic          req_mr_o,
   output logic [AW-1:0] req_addr_o,
   output logic [1:0]    req_be_o,
   output logic [DW-1:0] req_wdata_o,
   input  logic [DW-1:0] rd_data_i
);

   localparam int unsigned MIN_MAX = max4(MIN_D1, MIN_D2, MIN_D3, MIN_D4);
   localparam int unsigned CNT_W   = $clog2(MIN_MAX + 2) + 1;

   if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
      $error("DW must be an even width of at least 2");
   end
   if (MIN_D1 < 4 || MIN_D2 < 4 || MIN_D3 < 4 || MIN_D4 < 4) begin : g_bad_min
      $error("minimum acknowledge edges must be at least 4");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   hbs_state_e    state;
   logic          accept, cont, cap_wr, ack_go, is_read, rd_ready, in_cycle;
   logic [DW-1:0] wbuf;
   logic [1:0]    wbe;

   hbs_cycle_ctrl #(
      .CNT_W (CNT_W),
      .MIN_D1(MIN_D1), .MIN_D2(MIN_D2), .MIN_D3(MIN_D3), .MIN_D4(MIN_D4)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n_i),
      .as_n_i    (as_n_i),
      .uds_n_i   (uds_n_i),
      .lds_n_i   (lds_n_i),
      .rw_i      (rw_i),
      .cfg_div_i (cfg_div_i),
      .rd_ready_i(rd_ready),
      .state_o   (state),
      .accept_o  (accept),
      .cont_o    (cont),
      .cap_wr_o  (cap_wr),
      .ack_go_o  (ack_go),
      .is_read_o (is_read)
   );

   hbs_wr_buffer #(.DW(DW)) u_wbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap_wr),
      .uds_n_i(uds_n_i),
      .lds_n_i(lds_n_i),
      .data_i (data_i),
      .wbuf_o (wbuf),
      .be_o   (wbe)
   );

   assign in_cycle = (state == ST_ACTIVE) | (state == ST_ACK);

   hbs_rd_path #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .cont_i    (cont),
      .in_cycle_i(in_cycle),
      .is_read_i (is_read),
      .uds_n_i   (uds_n_i),
      .lds_n_i   (lds_n_i),
      .rd_data_i (rd_data_i),
      .ready_o   (rd_ready),
      .data_o    (data_o),
      .data_oe_o (data_oe_o)
   );

   // Acknowledge line: driven high as soon as selected, low only in ACK
   assign dtack_oe_o = (state != ST_IDLE) | (~cs_n_i & ~as_n_i);
   assign dtack_n_o  = ~((state == ST_ACK) & ~as_n_i);

   // Internal request port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o       <= 1'b0;
         req_we_o    <= 1'b0;
         req_mr_o    <= 1'b0;
         req_addr_o  <= '0;
         req_be_o    <= 2'b00;
         req_wdata_o <= '0;
      end else begin
         req_o <= 1'b0;
         if (accept) begin
            req_addr_o <= addr_i;
            req_mr_o   <= mr_i;
            req_we_o   <= 1'b0;
            req_be_o   <= {~uds_n_i, ~lds_n_i};
            req_o      <= rw_i;
         end else if (ack_go && !is_read) begin
            req_o       <= 1'b1;
            req_we_o    <= 1'b1;
            req_be_o    <= wbe;
            req_wdata_o <= wbuf;
         end
      end
   end

endmodule

// File: rtl/hbs_checker.sv
`timescale 1ns/1ps
module hbs_checker #(
   parameter int unsigned MIN_FLOOR = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       as_n_i,
   input logic       uds_n_i,
   input logic       lds_n_i,
   input logic       data_oe_o,
   input logic       dtack_n_o,
   input logic       dtack_oe_o,
   input logic       req_o,
   input logic       req_we_o,
   input logic [1:0] req_be_o
);

   logic [7:0] drv_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                 drv_cnt <= '0;
      else if (!dtack_oe_o)       drv_cnt <= '0;
      else if (drv_cnt != 8'hFF)  drv_cnt <= drv_cnt + 8'd1;
   end

   AST_ACK_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n_o |-> dtack_oe_o); // R3

   AST_ACK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n_o) |-> (drv_cnt >= 8'(MIN_FLOOR))); // R3

   AST_BUS_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> (!uds_n_i || !lds_n_i)); // R7

   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n_i && $past(as_n_i)) |-> !dtack_oe_o); // R8

   AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |=> !req_o); // R11

   AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && req_we_o) |-> (req_be_o != 2'b00)); // R5

endmodule

bind hbs_bus_slave hbs_checker #(.MIN_FLOOR(MIN_D1)) u_hbs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .as_n_i    (as_n_i),
   .uds_n_i   (uds_n_i),
   .lds_n_i   (lds_n_i),
   .data_oe_o (data_oe_o),
   .dtack_n_o (dtack_n_o),
   .dtack_oe_o(dtack_oe_o),
   .req_o     (req_o),
   .req_we_o  (req_we_o),
   .req_be_o  (req_be_o)
);

// File: tb/hbs_bus_slave_tb_top.sv
`timescale 1ns/1ps
module hbs_bus_slave_tb_top;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int RD_LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_div_i = 2'b00;
   logic          cs_n_i = 1'b1, as_n_i = 1'b1, uds_n_i = 1'b1, lds_n_i = 1'b1;
   logic          rw_i = 1'b1, mr_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] data_i = '0;
   logic [DW-1:0] data_o, req_wdata_o, rd_data_i, req_addr_lo;
   logic          data_oe_o, dtack_n_o, dtack_oe_o, req_o, req_we_o, req_mr_o;
   logic [AW-1:0] req_addr_o;
   logic [1:0]    req_be_o;

   always #2.5 clk = ~clk;

   hbs_bus_slave #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div_i(cfg_div_i),
      .cs_n_i(cs_n_i), .as_n_i(as_n_i), .uds_n_i(uds_n_i), .lds_n_i(lds_n_i),
      .rw_i(rw_i), .mr_i(mr_i), .addr_i(addr_i), .data_i(data_i),
      .data_o(data_o), .data_oe_o(data_oe_o),
      .dtack_n_o(dtack_n_o), .dtack_oe_o(dtack_oe_o),
      .req_o(req_o), .req_we_o(req_we_o), .req_mr_o(req_mr_o),
      .req_addr_o(req_addr_o), .req_be_o(req_be_o), .req_wdata_o(req_wdata_o),
      .rd_data_i(rd_data_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int wr_cnt  = 0;
   bit done    = 1'b0;

   logic [15:0] mem    [64];
   logic [15:0] shadow [64];
   logic [15:0] pipe   [RD_LAT];
   logic [15:0] exp_q  [$];

   assign rd_data_i   = pipe[RD_LAT-1];
   assign req_addr_lo = req_addr_o;

   // Internal memory model with fixed read latency
   always @(posedge clk) begin
      if (req_o && req_we_o) begin
         wr_cnt <= wr_cnt + 1;
         if (req_be_o[1]) mem[req_addr_o[5:0]][15:8] <= req_wdata_o[15:8];
         if (req_be_o[0]) mem[req_addr_o[5:0]][7:0]  <= req_wdata_o[7:0];
      end
      if (req_o && !req_we_o) pipe[0] <= mem[req_addr_o[5:0]];
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: compares read data at each acknowledge fall
   logic dtack_prev = 1'b1;
   always @(negedge clk) begin
      if (rst_n && dtack_prev && !dtack_n_o && data_oe_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected read", 32'(data_o), 32'hFFFF_FFFF);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(data_o == e, "R6 read word", 32'(data_o), 32'(e));
         end
      end
      dtack_prev = dtack_n_o;
   end

   function automatic int min_for(input logic [1:0] d);
      case (d)
         2'd0: return 8;
         2'd1: return 11;
         2'd2: return 13;
         default: return 18;
      endcase
   endfunction

   // One host cycle; lanes bit1 = upper, bit0 = lower
   task automatic bus_cycle(input bit rd, input logic [5:0] a, input logic [1:0] lanes,
                            input logic [15:0] wd, input logic [1:0] div,
                            input int abort_at, input int hold_extra);
      int n;
      int wr_before;
      wr_before = wr_cnt;
      if (rd) exp_q.push_back(shadow[a]);
      @(negedge clk);
      cfg_div_i = div; addr_i = AW'(a); rw_i = rd; mr_i = a[0];
      data_i = ~wd; cs_n_i = 1'b0; as_n_i = 1'b0;
      #1;
      check(dtack_oe_o && dtack_n_o, "R2 ack driven high", {dtack_oe_o, dtack_n_o}, 2'b11);
      check(!data_oe_o, "R7 no drive before strobe", 32'(data_oe_o), 0);
      @(negedge clk);
      uds_n_i = ~lanes[1]; lds_n_i = ~lanes[0];
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            if (rd) begin
               check(req_o && !req_we_o && req_addr_o == AW'(a) && req_be_o == lanes
                     && req_mr_o == a[0], "R11 read request",
                     {req_o, req_we_o, req_be_o, req_addr_lo}, {2'b10, lanes, 10'b0, a});
               #1 check(data_oe_o, "R6 bus driven on read", 32'(data_oe_o), 1);
            end else begin
               check(!req_o, "R11 no write request early", 32'(req_o), 0);
            end
         end
         if (!rd && n == 2) data_i = wd;
         if (!rd && n == 3) data_i = ~wd;
         if (abort_at != 0 && n == abort_at) begin
            as_n_i = 1'b1; cs_n_i = 1'b1; uds_n_i = 1'b1; lds_n_i = 1'b1;
            #1;
            check(dtack_oe_o && dtack_n_o, "R9 ack high after abort",
                  {dtack_oe_o, dtack_n_o}, 2'b11);
            @(negedge clk);
            check(!dtack_oe_o, "R9 released after abort", 32'(dtack_oe_o), 0);
            repeat (3) @(negedge clk);
            check(wr_cnt == wr_before, "R9 no write issued", wr_cnt, wr_before);
            return;
         end
         if (!dtack_n_o || n > 40) break;
      end
      check(n == min_for(div), "R3 acknowledge edge", n, min_for(div));
      if (!rd) begin
         logic [15:0] m;
         m = {{8{lanes[1]}}, {8{lanes[0]}}};
         check(req_o && req_we_o && req_be_o == lanes && (req_wdata_o & m) == (wd & m),
               "R5 R11 write request", {req_be_o, req_wdata_o & m}, {lanes, wd & m});
         if (lanes[1]) shadow[a][15:8] = wd[15:8];
         if (lanes[0]) shadow[a][7:0]  = wd[7:0];
      end
      for (int k = 0; k < hold_extra; k++) begin
         @(negedge clk);
         check(!dtack_n_o && !req_o, "R10 held ack, no extra request",
               {dtack_n_o, req_o}, 2'b00);
      end
      @(negedge clk);
      as_n_i = 1'b1; cs_n_i = 1'b1; uds_n_i = 1'b1; lds_n_i = 1'b1;
      #1;
      check(!data_oe_o, "R7 bus released", 32'(data_oe_o), 0);
      check(dtack_oe_o && dtack_n_o, "R8 ack high before release",
            {dtack_oe_o, dtack_n_o}, 2'b11);
      @(negedge clk);
      check(!dtack_oe_o, "R8 ack released", 32'(dtack_oe_o), 0);
      if (!rd) check(wr_cnt == wr_before + 1, "R10 one write per cycle", wr_cnt, wr_before + 1);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]    = 16'h1000 + 16'(i) * 16'h0111;
         shadow[i] = 16'h1000 + 16'(i) * 16'h0111;
      end
      for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
      repeat (3) @(negedge clk);
      check(!dtack_oe_o && dtack_n_o && !data_oe_o && !req_o, "R12 reset state",
            {dtack_oe_o, dtack_n_o, data_oe_o, req_o}, 4'b0100);
      rst_n = 1'b1;
      @(negedge clk);
      check(!dtack_oe_o && !req_o, "R12 after reset", {dtack_oe_o, req_o}, 2'b00);

      // R1: select and address strobe without data strobes
      cs_n_i = 1'b0; as_n_i = 1'b0; rw_i = 1'b0;
      begin
         bit bad = 1'b0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (req_o || !dtack_n_o) bad = 1'b1;
         end
         check(!bad, "R1 no cycle without data strobe", 32'(bad), 0);
      end
      cs_n_i = 1'b1; as_n_i = 1'b1;
      @(negedge clk);
      @(negedge clk);

      // Full-word writes at each ratio (R3, R4)
      bus_cycle(1'b0, 6'd3,  2'b11, 16'hA5C3, 2'd0, 0, 0);
      bus_cycle(1'b0, 6'd10, 2'b11, 16'h1234, 2'd1, 0, 0);
      bus_cycle(1'b0, 6'd21, 2'b11, 16'hBEEF, 2'd2, 0, 0);
      bus_cycle(1'b0, 6'd42, 2'b11, 16'h0F0F, 2'd3, 0, 0);
      // Read back at each ratio (R6)
      bus_cycle(1'b1, 6'd3,  2'b11, 16'h0, 2'd3, 0, 0);
      bus_cycle(1'b1, 6'd10, 2'b11, 16'h0, 2'd2, 0, 0);
      bus_cycle(1'b1, 6'd21, 2'b11, 16'h0, 2'd1, 0, 0);
      bus_cycle(1'b1, 6'd42, 2'b11, 16'h0, 2'd0, 0, 0);
      // Byte lanes (R5), read of one lane returns full word (R6)
      bus_cycle(1'b0, 6'd5, 2'b10, 16'h77AA, 2'd0, 0, 0);
      bus_cycle(1'b0, 6'd6, 2'b01, 16'h55CC, 2'd1, 0, 0);
      bus_cycle(1'b1, 6'd5, 2'b01, 16'h0, 2'd0, 0, 0);
      bus_cycle(1'b1, 6'd6, 2'b10, 16'h0, 2'd0, 0, 0);
      // Aborted write (R9) then read back unchanged
      bus_cycle(1'b0, 6'd7, 2'b11, 16'hDEAD, 2'd0, 5, 0);
      bus_cycle(1'b1, 6'd7, 2'b11, 16'h0, 2'd0, 0, 0);
      // Strobes held long after acknowledge (R10)
      bus_cycle(1'b0, 6'd8, 2'b11, 16'hC001, 2'd0, 0, 5);
      bus_cycle(1'b1, 6'd8, 2'b11, 16'h0, 2'd0, 0, 4);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6 all reads compared", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule